// File: doc/BRIEF.md
# Interrupt Pacing and Aggregation Controller

This block sits between a group of interrupt sources and one host interrupt line. A rising edge on a source sets a bit in a status register, and software clears those bits by writing 1s to them. A control register selects how the host interrupt is paced. With aggregation off, the level interrupt asserts as soon as any status bit is pending. After a clear, it re-asserts only once a selectable minimum gap has passed. With aggregation on, a free-running period timer decides when an assertion may happen. An assertion takes place only at a timer expiry that finds a status bit pending.

Each assertion raises the level output and emits a one-cycle message pulse. Each clearing write emits a one-cycle de-assert pulse and drops the level output. All time values are derived at elaboration from the `CLK_MHZ` parameter.

Top module: `irq_pacer`

## Requirements
- R1: After reset, status_o, ctrl_o, level_irq_o, msg_pulse_o and deassert_evt_o are all 0.
- R2: A 0-to-1 edge on src_i[k] sets status bit k on the next clock edge, and a source held high does not set the bit again. A write with wr_sel_i=0 clears exactly the status bits where wr_data_i[N_SRC-1:0] is 1.
- R3: If a source edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: A write with wr_sel_i=1 loads the control fields: aggregation enable from bit 13, period select from bits 11:8 and gap select from bits 2:0. ctrl_o returns these fields in the same positions and reads every other bit as 0.
- R5: With aggregation off and no gap running, level_irq_o and msg_pulse_o rise on the clock edge after the one that made status non-zero.
- R6: A status write whose low N_SRC data bits are not all 0 makes deassert_evt_o high for one cycle and level_irq_o low on the following edge.
- R7: With aggregation off, after a de-assert at edge W with status still non-zero, the next assertion occurs at edge W+G. G = max(1, ceil(ns*CLK_MHZ/1000)), with ns = 96, 544, 1060, 2080, 4130, 8220, 16420, 32670 for gap codes 0..7.
- R8: With aggregation on, the period is P = 32*CLK_MHZ*2^code cycles. An assertion happens only at edge C+kP (k ≥ 1) after the control write at edge C, and only when status is non-zero at that expiry. The minimum gap does not apply in this mode.
- R9: With aggregation on, an expiry that finds status empty causes no assertion, and a bit set later waits for the next expiry.
- R10: Every control write restarts the aggregation period from zero.
- R11: level_irq_o stays high from an assertion until the next de-assert, and msg_pulse_o is high for exactly one cycle per assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Interrupt source lines (edge detected) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write 1 to clear), 1 control |
| wr_data_i | input | 32 | Write data |
| status_o | output | N_SRC | Pending status bits |
| ctrl_o | output | 32 | Control register readback |
| level_irq_o | output | 1 | Level host interrupt |
| msg_pulse_o | output | 1 | One-cycle message interrupt pulse per assertion |
| deassert_evt_o | output | 1 | One-cycle pulse per clearing write |

## Verification
The hardest cases are the re-assertions made inside the minimum gap. The first is a partial clear that leaves a bit pending. The second is a clear that coincides with a new source edge on the bit being cleared. The bench makes both happen for every gap code by driving the source change in the same cycle as the clearing write. It then measures the exact cycle distance to the next assertion. For aggregation, it clears status just after an expiry so that the next expiry finds nothing pending. It then rewrites the control register mid-period and checks that the assertion moves to a full period after that write.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       agg_en;
        logic [3:0] agg_sel;
        logic [2:0] gap_sel;
    } ctrl_t;

    localparam int unsigned AGG_BASE_US = 32;
    localparam int unsigned AGG_CODES   = 16;

    // approximate minimum gap per code, in nanoseconds
    function automatic int unsigned gap_ns(input logic [2:0] code);
        case (code)
            3'd0:    return 96;
            3'd1:    return 544;
            3'd2:    return 1060;
            3'd3:    return 2080;
            3'd4:    return 4130;
            3'd5:    return 8220;
            3'd6:    return 16420;
            default: return 32670;
        endcase
    endfunction

    // gap in clock cycles, rounded up, never below one
    function automatic int unsigned gap_cycles(input logic [2:0] code, input int unsigned mhz);
        int unsigned c;
        c = (gap_ns(code) * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] status_o
);

    typedef struct packed {
        logic [N_SRC-1:0] bits;
        logic [N_SRC-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        // a fresh edge overrides a clear of the same bit
        st_d.bits = (st_q.bits & ~clr_mask_i) | (src_i & ~st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.bits;

endmodule

// File: rtl/irq_agg_timer.sv
module irq_agg_timer #(
    parameter int unsigned CLK_MHZ = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [3:0] sel_i,
    input  logic       restart_i,
    output logic       expire_o
);
    import irq_pacer_pkg::*;

    localparam int unsigned BASE = AGG_BASE_US * CLK_MHZ;
    localparam int unsigned MAXP = BASE << (AGG_CODES - 1);
    localparam int unsigned CW   = (MAXP > 1) ? $clog2(MAXP) : 1;
    localparam logic [CW:0] BASE_W = (CW+1)'(BASE);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } at_t;

    at_t at_d, at_q;
    logic [CW:0]   period;
    logic [CW-1:0] last;
    logic          at_end;

    always_comb begin
        period = BASE_W << sel_i;
        last   = CW'(period - 1'b1);
        at_end = (at_q.cnt == last);
        at_d   = at_q;
        if (restart_i || !en_i) begin
            at_d.cnt = '0;
        end else if (at_end) begin
            at_d.cnt = '0;
        end else begin
            at_d.cnt = at_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            at_q <= '0;
        end else begin
            at_q <= at_d;
        end
    end

    assign expire_o = en_i && at_end && !restart_i;

endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
    parameter int unsigned CLK_MHZ = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] sel_i,
    output logic       busy_o
);
    import irq_pacer_pkg::*;

    localparam int unsigned GMAX = gap_cycles(3'd7, CLK_MHZ);
    localparam int unsigned GW   = (GMAX > 1) ? $clog2(GMAX) : 1;

    typedef struct packed {
        logic [GW-1:0] cnt;
    } gt_t;

    gt_t gt_d, gt_q;

    always_comb begin
        gt_d = gt_q;
        if (start_i) begin
            // remaining wait after the de-assert edge, so assertion lands G cycles later
            gt_d.cnt = GW'(gap_cycles(sel_i, CLK_MHZ) - 1);
        end else if (gt_q.cnt != '0) begin
            gt_d.cnt = gt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gt_q <= '0;
        end else begin
            gt_q <= gt_d;
        end
    end

    assign busy_o = (gt_q.cnt != '0);

endmodule

// File: rtl/irq_pacer.sv
module irq_pacer #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned CLK_MHZ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [31:0]      wr_data_i,
    output logic [N_SRC-1:0] status_o,
    output logic [31:0]      ctrl_o,
    output logic             level_irq_o,
    output logic             msg_pulse_o,
    output logic             deassert_evt_o
);
    import irq_pacer_pkg::*;

    typedef struct packed {
        ctrl_t ctrl;
        logic  level;
        logic  msg;
        logic  deas;
    } top_t;

    top_t             top_d, top_q;
    logic             wr_status, wr_ctrl;
    logic [N_SRC-1:0] clr_mask;
    logic             deas_req;
    logic             pending;
    logic             agg_expire;
    logic             gap_busy;
    logic             fire;
    logic             unused_wr;

    assign wr_status = wr_en_i && (wr_sel_i == SEL_STATUS);
    assign wr_ctrl   = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign clr_mask  = wr_status ? wr_data_i[N_SRC-1:0] : '0;
    assign deas_req  = |clr_mask;
    assign unused_wr = ^wr_data_i;

    irq_status_bits #(.N_SRC(N_SRC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .clr_mask_i(clr_mask),
        .status_o  (status_o)
    );

    irq_agg_timer #(.CLK_MHZ(CLK_MHZ)) u_agg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (top_q.ctrl.agg_en),
        .sel_i    (top_q.ctrl.agg_sel),
        .restart_i(wr_ctrl),
        .expire_o (agg_expire)
    );

    irq_gap_timer #(.CLK_MHZ(CLK_MHZ)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(deas_req),
        .sel_i  (top_q.ctrl.gap_sel),
        .busy_o (gap_busy)
    );

    assign pending = |status_o;

    always_comb begin
        fire = !deas_req && !top_q.level && pending &&
               (top_q.ctrl.agg_en ? agg_expire : !gap_busy);

        top_d      = top_q;
        top_d.msg  = 1'b0;
        top_d.deas = deas_req;
        if (wr_ctrl) begin
            top_d.ctrl.agg_en  = wr_data_i[13];
            top_d.ctrl.agg_sel = wr_data_i[11:8];
            top_d.ctrl.gap_sel = wr_data_i[2:0];
        end
        if (deas_req) begin
            top_d.level = 1'b0;
        end else if (fire) begin
            top_d.level = 1'b1;
            top_d.msg   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign ctrl_o         = {18'b0, top_q.ctrl.agg_en, 1'b0, top_q.ctrl.agg_sel,
                             5'b0, top_q.ctrl.gap_sel};
    assign level_irq_o    = top_q.level;
    assign msg_pulse_o    = top_q.msg;
    assign deassert_evt_o = top_q.deas;

endmodule

// File: rtl/irq_pacer_chk.sv
module irq_pacer_chk #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned CLK_MHZ = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [N_SRC-1:0] wr_low_i,
    input logic [N_SRC-1:0] status_o,
    input logic             agg_en_i,
    input logic [2:0]       gap_sel_i,
    input logic             level_irq_o,
    input logic             msg_pulse_o,
    input logic             deassert_evt_o
);
    import irq_pacer_pkg::*;

    logic [N_SRC-1:0] src_prev_q;
    logic [N_SRC-1:0] rise;
    int unsigned      since_clr_q;
    logic [2:0]       clr_code_q;

    assign rise = src_i & ~src_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev_q  <= '0;
            since_clr_q <= 32'hFFFF_FFFF;
            clr_code_q  <= '0;
        end else begin
            src_prev_q <= src_i;
            if (deassert_evt_o) begin
                since_clr_q <= 1;
                clr_code_q  <= gap_sel_i;
            end else if (since_clr_q != 32'hFFFF_FFFF) begin
                since_clr_q <= since_clr_q + 1;
            end
        end
    end

    // R2 / R3: every source edge shows up in status on the next edge
    p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((status_o & $past(rise)) == $past(rise)));

    // R6
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i && (|wr_low_i)) |=> (deassert_evt_o && !level_irq_o));

    // R11
    p_msg_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse_o |=> !msg_pulse_o);

    // R5 / R11: the pulse marks exactly a rise of the level line
    p_msg_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse_o |-> (level_irq_o && !$past(level_irq_o)));

    // R11
    p_fall_needs_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_irq_o) |-> deassert_evt_o);

    // R7
    p_gap_respected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(level_irq_o) && !$past(agg_en_i)) |->
            (since_clr_q >= gap_cycles(clr_code_q, CLK_MHZ)));

endmodule

bind irq_pacer irq_pacer_chk #(.N_SRC(N_SRC), .CLK_MHZ(CLK_MHZ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_i         (src_i),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_low_i      (wr_data_i[N_SRC-1:0]),
    .status_o      (status_o),
    .agg_en_i      (ctrl_o[13]),
    .gap_sel_i     (ctrl_o[2:0]),
    .level_irq_o   (level_irq_o),
    .msg_pulse_o   (msg_pulse_o),
    .deassert_evt_o(deassert_evt_o)
);

// File: tb/sim_irq_pacer.sv
`timescale 1ns/1ps
module sim_irq_pacer;
    localparam int unsigned N   = 4;
    localparam int unsigned MHZ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic          wr_en_i = 1'b0;
    logic          wr_sel_i = 1'b0;
    logic [31:0]   wr_data_i = '0;
    logic [N-1:0]  status_o;
    logic [31:0]   ctrl_o;
    logic          level_irq_o, msg_pulse_o, deassert_evt_o;

    int     n_chk = 0;
    int     n_err = 0;
    bit     done  = 1'b0;
    longint cyc   = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_pacer #(.N_SRC(N), .CLK_MHZ(MHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .status_o(status_o),
        .ctrl_o(ctrl_o), .level_irq_o(level_irq_o), .msg_pulse_o(msg_pulse_o),
        .deassert_evt_o(deassert_evt_o)
    );

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input longint n);
        for (longint i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] data, input logic [N-1:0] srcv);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = data;
        src_i     = srcv;
        step(1);
        wr_en_i   = 1'b0;
    endtask

    task automatic wait_rise(input longint limit, output longint at);
        at = -1;
        for (longint i = 0; i < limit; i++) begin
            step(1);
            if (level_irq_o) begin
                at = cyc;
                check_eq("R11 pulse with rise", msg_pulse_o, 1);
                break;
            end
        end
    endtask

    function automatic longint exp_gap(input int code);
        longint ns, c;
        case (code)
            0: ns = 96;    1: ns = 544;   2: ns = 1060;  3: ns = 2080;
            4: ns = 4130;  5: ns = 8220;  6: ns = 16420; default: ns = 32670;
        endcase
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        longint w, at, g, p, wr_c;
        @(negedge clk);
        step(3);
        // R1
        check_eq("R1 status", status_o, 0);
        check_eq("R1 ctrl", ctrl_o, 0);
        check_eq("R1 level", level_irq_o, 0);
        check_eq("R1 msg", msg_pulse_o, 0);
        check_eq("R1 deassert", deassert_evt_o, 0);
        rst_n = 1'b1;
        step(2);

        // R4 control field placement and reserved bits
        wr(1'b1, 32'hFFFF_FFFF, '0);
        check_eq("R4 all ones", ctrl_o, 32'h0000_2F07);
        wr(1'b1, 32'h0000_1234, '0);
        check_eq("R4 mixed", ctrl_o, 32'h0000_0204);
        wr(1'b1, 32'h0000_2000, '0);
        check_eq("R4 enable only", ctrl_o, 32'h0000_2000);
        wr(1'b1, 32'h0, '0);
        check_eq("R4 zero", ctrl_o, 0);
        check_eq("R4 no assert", level_irq_o, 0);

        // gap sweep, aggregation off
        for (int c = 0; c < 8; c++) begin
            g = exp_gap(c);
            wr(1'b1, 32'(c), '0);
            src_i = 4'b0011;
            step(1);
            check_eq("R2 edge sets", status_o, 3);
            check_eq("R5 not yet", level_irq_o, 0);
            step(1);
            check_eq("R5 level", level_irq_o, 1);
            check_eq("R5 msg", msg_pulse_o, 1);
            step(1);
            check_eq("R11 msg one cycle", msg_pulse_o, 0);
            check_eq("R11 level held", level_irq_o, 1);

            wr(1'b0, 32'h1, 4'b0011);
            w = cyc;
            check_eq("R6 deassert pulse", deassert_evt_o, 1);
            check_eq("R6 level low", level_irq_o, 0);
            check_eq("R2 partial clear", status_o, 2);
            wait_rise(g + 8, at);
            check_eq("R7 partial clear gap", at - w, g);
            step(1);
            check_eq("R6 pulse one cycle", deassert_evt_o, 0);

            wr(1'b0, 32'h6, 4'b0111);
            w = cyc;
            check_eq("R3 set wins", status_o, 4);
            wait_rise(g + 8, at);
            check_eq("R7 new edge gap", at - w, g);

            wr(1'b0, 32'hF, 4'b0111);
            step(g + 4);
            check_eq("R2 held source no reset", status_o, 0);
            check_eq("R6 stays low", level_irq_o, 0);
            src_i = '0;
            step(1);
        end

        // aggregation sweep
        for (int c = 0; c < 4; c++) begin
            p = longint'(32 * MHZ) << c;
            wr(1'b1, 32'h2000 | (32'(c) << 8), 4'b0001);
            w = cyc;
            step(1);
            check_eq("R8 no immediate assert", level_irq_o, 0);
            wait_rise(p + 5, at);
            check_eq("R8 first expiry", at - w, p);
            wr(1'b0, 32'h1, '0);
            check_eq("R6 agg deassert", deassert_evt_o, 1);
            step(w + 2 * p + 10 - cyc);
            check_eq("R9 empty expiry", level_irq_o, 0);
            src_i = 4'b0001;
            wait_rise(p + 5, at);
            check_eq("R9 waits next expiry", at - w, 3 * p);
            wr(1'b0, 32'h1, '0);
            step(4);
            src_i = 4'b0001;
            step(1);
            step(w + 3 * p + p / 2 - cyc);
            wr(1'b1, 32'h2000 | (32'(c) << 8), 4'b0001);
            wr_c = cyc;
            wait_rise(2 * p, at);
            check_eq("R10 restart", at - wr_c, p);
            step(p + 3);
            check_eq("R11 held over expiry", level_irq_o, 1);
            check_eq("R11 no repeat msg", msg_pulse_o, 0);
            wr(1'b0, 32'hF, '0);
            wr(1'b1, 32'h0, '0);
            step(2);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule